// File: doc/BRIEF.md
# Multi-Buffer Pool Transfer Controller

This block moves packet data between a shared single-port RAM and a streaming port. The RAM holds a pool of eight buffers of 512 lines each, 32 bits per line, with buffer n at lines n*512 through n*512+511. Firmware issues one packed command word that names a buffer, a port, one operation (read, write or clear), an address step and a line range. A read streams buffer lines out to the port. A write fills buffer lines from the port. A clear returns a buffer to the idle state.

While a transfer runs, the block generates the RAM line address. The address starts at the first line and advances by the step after every accepted word. Each buffer keeps done, error and slow-path flags, plus an idle indication derived from them, along with the line offset of the last word it moved. Firmware must clear done, error and slow-path explicitly before the buffer can be used again. A single transfer engine serves the pool, so only one transfer is in flight at a time.

Top module: `bufpool_ctrl`

## Requirements
- R1: The command word holds these fields: buffer 31:28, port 27:25, clear 24, read 23, write 22, step 21:18, last line 17:9, first line 8:0. A command is ignored when the buffer value is 8 or more, or when not exactly one of clear/read/write is set. A read or write is also ignored when the port value is 4 or more.
- R2: The status word holds done flags in 7:0, error flags in 15:8, idle flags in 23:16 and slow-path flags in 31:24, with bit n of each byte belonging to buffer n. After reset it reads 0x00FF0000.
- R3: The RAM address is {buffer, line}. The line starts at the first line and advances by the step after each accepted word. A step of 0 acts as 1.
- R4: The word at line L is the final word when L + step > last line. After it, the done bit is set and the buffer's last-line register holds L. When the first line exceeds the last line, exactly one word moves.
- R5: A read raises out_valid with out_data taken from the RAM at the current address. out_eop marks the final word. The transfer advances only when out_valid and out_ready are both high, and holds its address otherwise.
- R6: A write raises in_ready and writes every accepted in_data word to the current address. If in_eop arrives on an accepted word, the transfer ends there with done set and that line recorded.
- R7: If in_err arrives on an accepted write word, the transfer ends with the error bit set and the done bit clear, and that line is recorded.
- R8: A buffer's idle flag is set only when it is not done, not in error and not transferring. A started read or write clears the idle flag in the cycle after the command.
- R9: A read or write aimed at a buffer that is not idle is ignored. So is any read or write issued while another transfer is active.
- R10: A clear removes the target buffer's done, error and slow-path flags. If the target is the active buffer, the transfer is aborted without setting done.
- R11: A bit of sp_set sets that buffer's slow-path flag, regardless of the other flags. A set wins over a clear in the same cycle.
- R12: ll_line shows the last-line register of the buffer chosen by ll_sel. Every last-line register reads 0 after reset.
- R13: xfer_port shows the port field of the active transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word strobe |
| cmd_word | input | 32 | Packed command |
| sp_set | input | 8 | Slow-path set mask from the packet classifier |
| ram_addr | output | 12 | RAM line address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM read data for ram_addr, same cycle |
| out_valid | output | 1 | Read stream word valid |
| out_data | output | 32 | Read stream data |
| out_eop | output | 1 | Read stream final word |
| out_ready | input | 1 | Read stream sink ready |
| in_valid | input | 1 | Write stream word valid |
| in_data | input | 32 | Write stream data |
| in_eop | input | 1 | Write stream end of packet |
| in_err | input | 1 | Write stream error |
| in_ready | output | 1 | Write stream accepting |
| xfer_port | output | 3 | Port field of the active transfer |
| stat_word | output | 32 | Per-buffer flag word |
| ll_sel | input | 3 | Buffer selector for last-line readout |
| ll_line | output | 9 | Last line moved in the selected buffer |

## Verification
Some rules hold on every cycle and are checked there. A stalled read keeps its address and valid. A running transfer keeps its buffer until it ends or is aborted. Last-line registers and done flags change only on an end event for their own buffer. A slow-path set always lands, and a clear without a same-cycle set empties all three flags. The bench scenarios are needed to show the address sequences for various steps and ranges, early end-of-packet, error endings, the rejection of malformed and mistimed commands, and the abort of a live transfer. Those scenarios also show that data read back matches what the RAM holds.

// File: rtl/bp_pkg.sv
package bp_pkg;
    localparam int BP_NBUF   = 8;
    localparam int BP_BUF_W  = $clog2(BP_NBUF);
    localparam int BP_BSEL_W = 4;
    localparam int BP_LINE_W = 9;
    localparam int BP_STEP_W = 4;
    localparam int BP_PORT_W = 3;
    localparam int BP_NPORT  = 4;
    localparam int BP_ADDR_W = BP_BUF_W + BP_LINE_W;

    typedef struct packed {
        logic [BP_BSEL_W-1:0] bsel;
        logic [BP_PORT_W-1:0] port;
        logic                 op_clr;
        logic                 op_rd;
        logic                 op_wr;
        logic [BP_STEP_W-1:0] step;
        logic [BP_LINE_W-1:0] last;
        logic [BP_LINE_W-1:0] first;
    } bp_cmd_t;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_READ  = 2'd1,
        ENG_WRITE = 2'd2
    } eng_st_e;

    // zero step is promoted to one so a transfer always makes progress
    function automatic logic [BP_LINE_W:0] eff_step(input logic [BP_STEP_W-1:0] s);
        return (s == '0) ? (BP_LINE_W+1)'(1) : (BP_LINE_W+1)'(s);
    endfunction
endpackage

// File: rtl/bp_cmd_decode.sv
module bp_cmd_decode
    import bp_pkg::*;
(
    input  logic                cmd_valid,
    input  logic [31:0]         cmd_word,
    input  logic [BP_NBUF-1:0]  idle_mask,
    input  logic                eng_busy,
    output bp_cmd_t             cmd,
    output logic [BP_BUF_W-1:0] tgt_buf,
    output logic                clr_go,
    output logic                start_go,
    output logic                start_rd
);
    logic buf_ok, one_op, port_ok;

    always_comb begin
        cmd      = bp_cmd_t'(cmd_word);
        tgt_buf  = cmd.bsel[BP_BUF_W-1:0];
        buf_ok   = cmd.bsel < BP_BSEL_W'(BP_NBUF);
        one_op   = $countones({cmd.op_clr, cmd.op_rd, cmd.op_wr}) == 1;
        port_ok  = cmd.port < BP_PORT_W'(BP_NPORT);
        clr_go   = cmd_valid && buf_ok && one_op && cmd.op_clr;
        start_go = cmd_valid && buf_ok && one_op && (cmd.op_rd || cmd.op_wr)
                   && port_ok && idle_mask[tgt_buf] && !eng_busy;
        start_rd = cmd.op_rd;
    end
endmodule

// File: rtl/bp_xfer_engine.sv
module bp_xfer_engine
    import bp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_go,
    input  logic                 start_rd,
    input  logic                 abort,
    input  logic [BP_BUF_W-1:0]  tgt_buf,
    input  bp_cmd_t              cmd,
    input  logic                 out_ready,
    input  logic                 in_valid,
    input  logic                 in_eop,
    input  logic                 in_err,
    output logic [BP_ADDR_W-1:0] ram_addr,
    output logic                 ram_we,
    output logic                 out_valid,
    output logic                 out_eop,
    output logic                 in_ready,
    output logic                 busy,
    output logic [BP_BUF_W-1:0]  cur_buf,
    output logic [BP_PORT_W-1:0] xfer_port,
    output logic                 end_done,
    output logic                 end_err,
    output logic [BP_LINE_W-1:0] end_line
);
    eng_st_e              st_q;
    logic [BP_LINE_W-1:0] line_q, last_q;
    logic [BP_LINE_W:0]   step_q;
    logic                 fin_last, rd_beat, wr_beat;

    always_comb begin
        fin_last  = ({1'b0, line_q} + step_q) > {1'b0, last_q};
        rd_beat   = (st_q == ENG_READ) && out_ready;
        wr_beat   = (st_q == ENG_WRITE) && in_valid;
        end_err   = wr_beat && in_err;
        end_done  = (rd_beat && fin_last) || (wr_beat && !in_err && (fin_last || in_eop));
        ram_we    = wr_beat;
        out_valid = (st_q == ENG_READ);
        out_eop   = (st_q == ENG_READ) && fin_last;
        in_ready  = (st_q == ENG_WRITE);
        busy      = (st_q != ENG_IDLE);
        end_line  = line_q;
        ram_addr  = {cur_buf, line_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ENG_IDLE;
            cur_buf   <= '0;
            line_q    <= '0;
            last_q    <= '0;
            step_q    <= '0;
            xfer_port <= '0;
        end else if (abort || end_done || end_err) begin
            st_q <= ENG_IDLE;
        end else if (st_q == ENG_IDLE && start_go) begin
            st_q      <= start_rd ? ENG_READ : ENG_WRITE;
            cur_buf   <= tgt_buf;
            line_q    <= cmd.first;
            last_q    <= cmd.last;
            step_q    <= eff_step(cmd.step);
            xfer_port <= cmd.port;
        end else if (rd_beat || wr_beat) begin
            line_q <= line_q + step_q[BP_LINE_W-1:0];
        end
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready && !abort |=> out_valid && $stable(ram_addr)) // R5
        else $error("stalled read moved");

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        busy && !end_done && !end_err && !abort |=> busy && $stable(cur_buf)) // R9
        else $error("active transfer changed buffer");
endmodule

// File: rtl/bp_status_regs.sv
module bp_status_regs
    import bp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 end_done,
    input  logic                 end_err,
    input  logic [BP_BUF_W-1:0]  end_buf,
    input  logic [BP_LINE_W-1:0] end_line,
    input  logic                 clr_go,
    input  logic [BP_BUF_W-1:0]  clr_buf,
    input  logic [BP_NBUF-1:0]   sp_set,
    input  logic                 busy,
    input  logic [BP_BUF_W-1:0]  cur_buf,
    input  logic [BP_BUF_W-1:0]  ll_sel,
    output logic [4*BP_NBUF-1:0] stat_word,
    output logic [BP_NBUF-1:0]   idle_mask,
    output logic [BP_LINE_W-1:0] ll_line
);
    logic [BP_NBUF-1:0]   done_q, err_q, sp_q, active;
    logic [BP_LINE_W-1:0] ll_q [BP_NBUF];

    always_comb begin
        active    = busy ? (BP_NBUF'(1) << cur_buf) : '0;
        idle_mask = ~done_q & ~err_q & ~active;
        stat_word = {sp_q, idle_mask, err_q, done_q};
        ll_line   = ll_q[ll_sel];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= '0;
            err_q  <= '0;
            sp_q   <= '0;
            for (int i = 0; i < BP_NBUF; i++) ll_q[i] <= '0;
        end else begin
            for (int i = 0; i < BP_NBUF; i++) begin
                logic hit_end, hit_clr;
                hit_end = (end_done || end_err) && (end_buf == BP_BUF_W'(i));
                hit_clr = clr_go && (clr_buf == BP_BUF_W'(i));
                if (hit_end) ll_q[i] <= end_line;
                if (hit_clr) begin
                    done_q[i] <= 1'b0;
                    err_q[i]  <= 1'b0;
                end else begin
                    if (hit_end && end_done) done_q[i] <= 1'b1;
                    if (hit_end && end_err)  err_q[i]  <= 1'b1;
                end
                sp_q[i] <= (sp_q[i] && !hit_clr) || sp_set[i];
            end
        end
    end

    for (genvar g = 0; g < BP_NBUF; g++) begin : g_chk
        AST_SP_STICKY: assert property (@(posedge clk) disable iff (rst)
            sp_set[g] |=> sp_q[g]) // R11
            else $error("slow-path set lost");

        AST_CLR_FLAGS: assert property (@(posedge clk) disable iff (rst)
            clr_go && clr_buf == BP_BUF_W'(g) && !sp_set[g] |=> !done_q[g] && !err_q[g] && !sp_q[g]) // R10
            else $error("clear left a flag");

        AST_LL_HOLD: assert property (@(posedge clk) disable iff (rst)
            !((end_done || end_err) && end_buf == BP_BUF_W'(g)) |=> $stable(ll_q[g])) // R4
            else $error("last line changed without end");

        AST_DONE_SRC: assert property (@(posedge clk) disable iff (rst)
            !done_q[g] && !(end_done && end_buf == BP_BUF_W'(g)) |=> !done_q[g]) // R4
            else $error("done rose without completion");
    end
endmodule

// File: rtl/bufpool_ctrl.sv
module bufpool_ctrl
    import bp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    input  logic [31:0]          cmd_word,
    input  logic [BP_NBUF-1:0]   sp_set,
    output logic [BP_ADDR_W-1:0] ram_addr,
    output logic                 ram_we,
    output logic [DATA_W-1:0]    ram_wdata,
    input  logic [DATA_W-1:0]    ram_rdata,
    output logic                 out_valid,
    output logic [DATA_W-1:0]    out_data,
    output logic                 out_eop,
    input  logic                 out_ready,
    input  logic                 in_valid,
    input  logic [DATA_W-1:0]    in_data,
    input  logic                 in_eop,
    input  logic                 in_err,
    output logic                 in_ready,
    output logic [BP_PORT_W-1:0] xfer_port,
    output logic [4*BP_NBUF-1:0] stat_word,
    input  logic [BP_BUF_W-1:0]  ll_sel,
    output logic [BP_LINE_W-1:0] ll_line
);
    bp_cmd_t              cmd;
    logic [BP_BUF_W-1:0]  tgt_buf, cur_buf;
    logic [BP_NBUF-1:0]   idle_mask;
    logic                 clr_go, start_go, start_rd, busy, abort;
    logic                 end_done, end_err;
    logic [BP_LINE_W-1:0] end_line;

    assign abort     = clr_go && busy && (tgt_buf == cur_buf);
    assign ram_wdata = in_data;
    assign out_data  = ram_rdata;

    bp_cmd_decode u_dec (
        .cmd_valid(cmd_valid), .cmd_word(cmd_word), .idle_mask(idle_mask),
        .eng_busy(busy), .cmd(cmd), .tgt_buf(tgt_buf), .clr_go(clr_go),
        .start_go(start_go), .start_rd(start_rd)
    );

    bp_xfer_engine u_eng (
        .clk(clk), .rst(rst), .start_go(start_go), .start_rd(start_rd),
        .abort(abort), .tgt_buf(tgt_buf), .cmd(cmd), .out_ready(out_ready),
        .in_valid(in_valid), .in_eop(in_eop), .in_err(in_err),
        .ram_addr(ram_addr), .ram_we(ram_we), .out_valid(out_valid),
        .out_eop(out_eop), .in_ready(in_ready), .busy(busy), .cur_buf(cur_buf),
        .xfer_port(xfer_port), .end_done(end_done), .end_err(end_err),
        .end_line(end_line)
    );

    bp_status_regs u_stat (
        .clk(clk), .rst(rst), .end_done(end_done), .end_err(end_err),
        .end_buf(cur_buf), .end_line(end_line), .clr_go(clr_go),
        .clr_buf(tgt_buf), .sp_set(sp_set), .busy(busy), .cur_buf(cur_buf),
        .ll_sel(ll_sel), .stat_word(stat_word), .idle_mask(idle_mask),
        .ll_line(ll_line)
    );

    AST_ONE_STREAM: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && in_ready)) // R9
        else $error("both stream directions active");

    AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !stat_word[2*BP_NBUF + cur_buf]) // R8
        else $error("idle flag still set on a started buffer");
endmodule

// File: tb/bufpool_ctrl_tb.sv
module bufpool_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_word = '0;
    logic [7:0]  sp_set = '0;
    logic [11:0] ram_addr;
    logic        ram_we;
    logic [31:0] ram_wdata, ram_rdata, out_data, in_data = '0;
    logic        out_valid, out_eop, out_ready = 1'b0;
    logic        in_valid = 1'b0, in_eop = 1'b0, in_err = 1'b0, in_ready;
    logic [2:0]  xfer_port, ll_sel = '0;
    logic [31:0] stat_word;
    logic [8:0]  ll_line;

    logic [31:0] mem [4096];
    bit          exp_done [8], exp_err [8], exp_sp [8];
    int          exp_ll [8];
    int          n_chk = 0, n_err = 0;

    always #2.5 clk = ~clk;

    bufpool_ctrl dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .sp_set(sp_set), .ram_addr(ram_addr), .ram_we(ram_we),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .out_valid(out_valid),
        .out_data(out_data), .out_eop(out_eop), .out_ready(out_ready),
        .in_valid(in_valid), .in_data(in_data), .in_eop(in_eop),
        .in_err(in_err), .in_ready(in_ready), .xfer_port(xfer_port),
        .stat_word(stat_word), .ll_sel(ll_sel), .ll_line(ll_line)
    );

    assign ram_rdata = mem[ram_addr];
    always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // R1 field layout: buffer 31:28, port 27:25, clear 24, read 23, write 22, step 21:18, last 17:9, first 8:0
    function automatic logic [31:0] mk(int b, int p, bit c, bit r, bit w, int s, int l, int f);
        return {4'(b), 3'(p), c, r, w, 4'(s), 9'(l), 9'(f)};
    endfunction

    // R2 layout: done 7:0, error 15:8, idle 23:16, slow-path 31:24
    function automatic logic [31:0] exp_stat();
        logic [31:0] v = '0;
        for (int i = 0; i < 8; i++) begin
            v[i]      = exp_done[i];
            v[8 + i]  = exp_err[i];
            v[16 + i] = !exp_done[i] && !exp_err[i];
            v[24 + i] = exp_sp[i];
        end
        return v;
    endfunction

    task automatic send(input logic [31:0] w);
        cmd_valid = 1'b1;
        cmd_word  = w;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic clear_buf(input int b);
        send(mk(b, 0, 1, 0, 0, 0, 0, 0));
        exp_done[b] = 0; exp_err[b] = 0; exp_sp[b] = 0;
    endtask

    task automatic chk_ll(input int b, input string tag);
        ll_sel = 3'(b);
        #0.1;
        chk(tag, 32'(ll_line), 32'(exp_ll[b]));
    endtask

    task automatic do_write(input int b, input int p, input int f, input int l, input int s,
                            input int eop_at, input int err_at);
        int line = f;
        int es   = (s == 0) ? 1 : s;
        send(mk(b, p, 0, 0, 1, s, l, f));
        chk("R8 idle cleared on start", 32'(stat_word[16 + b]), 0);
        chk("R13 port shown", 32'(xfer_port), 32'(p));
        for (int k = 0; k < 600; k++) begin
            bit fin = (line + es > l) || (k == eop_at);
            bit er  = (k == err_at);
            in_valid = 1'b1; in_data = $urandom; in_eop = (k == eop_at); in_err = er;
            #0.1;
            chk("R6 in_ready", 32'(in_ready), 1);
            chk("R3 write address", 32'(ram_addr), 32'(b * 512 + line));
            @(negedge clk);
            chk("R6 data stored", mem[b * 512 + line], in_data);
            if (er) begin exp_err[b] = 1; exp_ll[b] = line; break; end
            if (fin) begin exp_done[b] = 1; exp_ll[b] = line; break; end
            line += es;
        end
        in_valid = 1'b0; in_eop = 1'b0; in_err = 1'b0;
        chk("R6 in_ready drops", 32'(in_ready), 0);
        chk("R4 status after write", stat_word, exp_stat());
        chk_ll(b, "R12 last line after write");
    endtask

    task automatic do_read(input int b, input int p, input int f, input int l, input int s);
        int line = f;
        int es   = (s == 0) ? 1 : s;
        send(mk(b, p, 0, 1, 0, s, l, f));
        for (int k = 0; k < 2000; k++) begin
            bit fin = (line + es > l);
            out_ready = ($urandom_range(0, 3) != 0);
            #0.1;
            if (out_ready) begin
                chk("R5 out_valid", 32'(out_valid), 1);
                chk("R3 read address", 32'(ram_addr), 32'(b * 512 + line));
                chk("R5 read data", out_data, mem[b * 512 + line]);
                chk("R5 eop marker", 32'(out_eop), 32'(fin));
                @(negedge clk);
                if (fin) begin exp_done[b] = 1; exp_ll[b] = line; break; end
                line += es;
            end else begin
                @(negedge clk);
            end
        end
        out_ready = 1'b0;
        chk("R5 out_valid drops", 32'(out_valid), 0);
        chk("R4 status after read", stat_word, exp_stat());
        chk_ll(b, "R12 last line after read");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 4096; i++) mem[i] = 32'(i) ^ 32'h5A5A_0000;
        for (int i = 0; i < 8; i++) begin exp_done[i] = 0; exp_err[i] = 0; exp_sp[i] = 0; exp_ll[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        chk("R2 reset status", stat_word, 32'h00FF_0000);
        chk("R5 reset out_valid", 32'(out_valid), 0);
        chk("R6 reset in_ready", 32'(in_ready), 0);
        chk_ll(5, "R12 reset last line");

        // basic write then a rejected second command on the done buffer
        do_write(2, 1, 10, 13, 1, -1, -1);
        send(mk(2, 0, 0, 1, 0, 1, 20, 0));
        chk("R9 non-idle read ignored", 32'(out_valid), 0);
        chk("R9 status unchanged", stat_word, exp_stat());

        // clear, then read back with stalls
        clear_buf(2);
        chk("R10 clear returns idle", stat_word, exp_stat());
        do_read(2, 3, 10, 13, 1);

        // stepping and zero step
        do_write(5, 0, 0, 10, 3, -1, -1);
        chk("R4 step 3 final line", 32'(exp_ll[5]), 9);
        do_write(6, 2, 5, 6, 0, -1, -1);

        // early end of packet, then error ending
        do_write(1, 2, 0, 100, 1, 2, -1);
        do_write(3, 1, 4, 9, 2, -1, 1);
        chk("R7 error bit, no done", {24'b0, stat_word[11], stat_word[3], stat_word[19], 5'b0}, 32'h80);

        // malformed commands
        send(mk(8, 0, 0, 1, 0, 1, 5, 0));
        chk("R1 buffer 8 ignored", 32'(out_valid), 0);
        send(mk(0, 0, 0, 1, 1, 1, 5, 0));
        chk("R1 two ops ignored", 32'({out_valid, in_ready}), 0);
        send(mk(0, 4, 0, 1, 0, 1, 5, 0));
        chk("R1 port 4 ignored", 32'(out_valid), 0);
        send(mk(2, 0, 1, 1, 0, 0, 0, 0));
        chk("R1 clear+read ignored", stat_word, exp_stat());

        // busy engine rejects a second start; clear aborts
        send(mk(4, 3, 0, 1, 0, 1, 50, 0));
        chk("R13 port of active read", 32'(xfer_port), 3);
        send(mk(0, 2, 0, 0, 1, 1, 5, 0));
        chk("R9 second start ignored", 32'({in_ready, xfer_port}), 32'({1'b0, 3'd3}));
        clear_buf(4);
        chk("R10 abort stops read", 32'(out_valid), 0);
        chk("R10 abort leaves idle, no done", stat_word, exp_stat());

        // first beyond last: one word
        do_read(0, 1, 20, 5, 4);
        chk("R4 single word line", 32'(exp_ll[0]), 20);

        // slow path
        sp_set = 8'h80; @(negedge clk); sp_set = 8'h00; exp_sp[7] = 1;
        chk("R11 slow-path set", stat_word, exp_stat());
        sp_set = 8'h80; send(mk(7, 0, 1, 0, 0, 0, 0, 0)); sp_set = 8'h00;
        chk("R11 set beats clear", 32'(stat_word[31]), 1);
        clear_buf(7);
        chk("R10 clear drops slow-path", stat_word, exp_stat());

        // constrained random transfers
        for (int it = 0; it < 24; it++) begin
            int b = $urandom_range(0, 7);
            int f = $urandom_range(0, 511);
            int l = f + $urandom_range(0, 23);
            int s = $urandom_range(0, 15);
            if (l > 511) l = 511;
            clear_buf(b);
            if (it % 2 == 0) do_write(b, $urandom_range(0, 3), f, l, s, -1, -1);
            else             do_read(b, $urandom_range(0, 3), f, l, s);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule